// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter driven by a static configuration word that arrives on input pins. The counter moves forward on a tick-enable strobe taken from a clock that has already been chosen upstream. When it reaches a timeout period, which is a power of two, it raises a watchdog event. The period field in use depends on whether the device is running or asleep. Software keeps the watchdog quiet by pulsing a clear strobe before the timeout.

An optional clear window can be switched on. In that case a clear is accepted only during the last part of the period, and the size of that part is a fraction picked by a two-bit code. A clear that comes earlier counts as a fault, and it raises the same event as a timeout. Each event produces one of two outcomes. One is a device reset request that stays asserted until reset. The other is a single-cycle trap pulse.

The watchdog runs whenever a hardware enable bit is set. When that bit is clear, a software on bit decides whether it runs.

Top module: `watchdog_win`

## Requirements
- R1: When running with `sleep_i`=0 and run code n on `cfg_run_ps`, the first event arrives on the 2^n-th tick-enabled clock edge after the count was last zeroed. Code 0 raises an event on every tick.
- R2: When `sleep_i`=1, code n on `cfg_sleep_ps` gives a period of 2^n ticks. Code 0 is the one exception and gives 2 ticks, the same as code 1.
- R3: The count changes only on clock edges where `tick_en` is 1. Edges without a tick leave it unchanged.
- R4: The window start is P minus a fraction of P, where P is the period. `cfg_win_sel` picks the fraction: 2'b11 is 1/4, 2'b10 is 3/8, 2'b01 is 1/2 and 2'b00 is 3/4. With the window on, `win_open` goes to 1 on the edge where the count reaches the window start.
- R5: With the window on (`cfg_win_dis`=0), a clear while the count is below the window start raises an event. A clear at or after the window start raises no event, and both kinds of clear zero the count.
- R6: With `cfg_win_dis`=1, a clear is accepted at any count and `win_open` stays 1 while the watchdog runs.
- R7: An event in run mode with `cfg_rst_en`=1 sets `rst_req`, and `rst_req` stays high until `rst`. With `cfg_rst_en`=0 the event instead produces a one-cycle `trap_pulse` and `rst_req` does not rise.
- R8: An event that happens while `sleep_i`=1 always produces a `trap_pulse` and never a reset request, whatever the value of `cfg_rst_en`.
- R9: The watchdog runs when `cfg_hw_en` or `sw_on` is 1. While both are 0, the count is held at zero, no event occurs and `win_open` is 0.
- R10: Any change of `sleep_i` zeroes the count on that edge. No tick is counted on that edge.
- R11: A synchronous active-high `rst` clears `rst_req`, `trap_pulse`, `win_open` and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable from the selected timebase |
| sleep_i | input | 1 | Device is in sleep mode |
| sw_clear | input | 1 | Software clear strobe |
| sw_on | input | 1 | Software run bit, used when `cfg_hw_en`=0 |
| cfg_hw_en | input | 1 | Forces the watchdog to run |
| cfg_rst_en | input | 1 | Run-mode event gives a reset request (1) or a trap (0) |
| cfg_win_dis | input | 1 | 1 turns the clear window off |
| cfg_win_sel | input | 2 | Window fraction code |
| cfg_run_ps | input | PS_W | Run-mode period code |
| cfg_sleep_ps | input | PS_W | Sleep-mode period code |
| rst_req | output | 1 | Sticky device reset request |
| trap_pulse | output | 1 | One-cycle trap on an event |
| win_open | output | 1 | A clear would be accepted now |

## Verification
The bench builds the block with its default parameters: a 32-bit counter and 5-bit period codes. Because the period codes are inputs rather than parameters, choosing codes from 0 to 4 brings every window fraction, the sleep-code floor and the single-tick period within reach in a few dozen cycles. With a 16-tick period, each of the four window starts (12, 10, 8 and 4) lands on a distinct whole count, so early and in-window clears can be placed exactly one count either side of each boundary.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

  typedef enum logic [1:0] {
    WSEL_THREE_QTR = 2'b00,
    WSEL_HALF      = 2'b01,
    WSEL_3_EIGHTHS = 2'b10,
    WSEL_QUARTER   = 2'b11
  } wsel_e;

  // Part of period p that forms the clear window, built from shifts only.
  function automatic logic [63:0] win_span(input logic [63:0] p, input wsel_e s);
    logic [63:0] half, qtr, eighth;
    half   = p >> 1;
    qtr    = p >> 2;
    eighth = p >> 3;
    case (s)
      WSEL_QUARTER:   win_span = qtr;
      WSEL_3_EIGHTHS: win_span = qtr + eighth;
      WSEL_HALF:      win_span = half;
      default:        win_span = half + qtr;
    endcase
  endfunction

endpackage

// File: rtl/wdog_period.sv
`timescale 1ns/1ps
module wdog_period
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PS_W  = 5,
  parameter int SLEEP_MIN_CODE = 1
) (
  input  logic             sleep_i,
  input  logic [PS_W-1:0]  run_ps,
  input  logic [PS_W-1:0]  sleep_ps,
  input  logic [1:0]       win_sel,
  output logic [CNT_W-1:0] last_cnt,
  output logic [CNT_W-1:0] open_at
);
  localparam int FULL_W = CNT_W + 1;

  logic [PS_W-1:0]   sleep_code;
  logic [PS_W-1:0]   code;
  logic [FULL_W-1:0] period;
  logic [63:0]       span;

  generate
    if (SLEEP_MIN_CODE > 0) begin : g_floor
      always_comb begin
        if (sleep_ps < PS_W'(SLEEP_MIN_CODE)) sleep_code = PS_W'(SLEEP_MIN_CODE);
        else                                  sleep_code = sleep_ps;
      end
    end else begin : g_nofloor
      always_comb sleep_code = sleep_ps;
    end
  endgenerate

  always_comb begin
    code     = sleep_i ? sleep_code : run_ps;
    period   = FULL_W'(1) << code;
    span     = win_span(64'(period), wsel_e'(win_sel));
    last_cnt = CNT_W'(period - FULL_W'(1));
    open_at  = CNT_W'(period - FULL_W'(span));
  end

endmodule

// File: rtl/wdog_count.sv
`timescale 1ns/1ps
module wdog_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             active,
  input  logic             sleep_i,
  input  logic             sw_clear,
  input  logic             win_dis,
  input  logic [CNT_W-1:0] last_cnt,
  input  logic [CNT_W-1:0] open_at,
  output logic             evt,
  output logic             open_nxt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sleep_q;

  always_comb begin
    cnt_d = cnt_q;
    evt   = 1'b0;
    if (!active || (sleep_i != sleep_q)) begin
      cnt_d = '0;
    end else if (sw_clear) begin
      cnt_d = '0;
      evt   = !win_dis && (cnt_q < open_at);
    end else if (tick_en) begin
      if (cnt_q >= last_cnt) begin
        cnt_d = '0;
        evt   = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
    open_nxt = active && (win_dis || (cnt_d >= open_at));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      sleep_q <= sleep_i;
    end else begin
      cnt_q   <= cnt_d;
      sleep_q <= sleep_i;
    end
  end

endmodule

// File: rtl/wdog_outcome.sv
`timescale 1ns/1ps
module wdog_outcome (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic sleep_i,
  input  logic rst_en,
  input  logic open_nxt,
  output logic rst_req,
  output logic trap_pulse,
  output logic win_open
);
  logic to_reset;

  always_comb to_reset = rst_en && !sleep_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req    <= 1'b0;
      trap_pulse <= 1'b0;
      win_open   <= 1'b0;
    end else begin
      rst_req    <= rst_req || (evt && to_reset);
      trap_pulse <= evt && !to_reset;
      win_open   <= open_nxt;
    end
  end

endmodule

// File: rtl/watchdog_win.sv
`timescale 1ns/1ps
module watchdog_win #(
  parameter int CNT_W = 32,
  parameter int PS_W  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_en,
  input  logic            sleep_i,
  input  logic            sw_clear,
  input  logic            sw_on,
  input  logic            cfg_hw_en,
  input  logic            cfg_rst_en,
  input  logic            cfg_win_dis,
  input  logic [1:0]      cfg_win_sel,
  input  logic [PS_W-1:0] cfg_run_ps,
  input  logic [PS_W-1:0] cfg_sleep_ps,
  output logic            rst_req,
  output logic            trap_pulse,
  output logic            win_open
);
  logic [CNT_W-1:0] last_cnt, open_at;
  logic             active, evt, open_nxt;

  always_comb active = cfg_hw_en || sw_on;

  wdog_period #(.CNT_W(CNT_W), .PS_W(PS_W), .SLEEP_MIN_CODE(1)) u_period (
    .sleep_i (sleep_i),
    .run_ps  (cfg_run_ps),
    .sleep_ps(cfg_sleep_ps),
    .win_sel (cfg_win_sel),
    .last_cnt(last_cnt),
    .open_at (open_at)
  );

  wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .active  (active),
    .sleep_i (sleep_i),
    .sw_clear(sw_clear),
    .win_dis (cfg_win_dis),
    .last_cnt(last_cnt),
    .open_at (open_at),
    .evt     (evt),
    .open_nxt(open_nxt)
  );

  wdog_outcome u_out (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .sleep_i   (sleep_i),
    .rst_en    (cfg_rst_en),
    .open_nxt  (open_nxt),
    .rst_req   (rst_req),
    .trap_pulse(trap_pulse),
    .win_open  (win_open)
  );

endmodule

// File: rtl/watchdog_win_chk.sv
`timescale 1ns/1ps
module watchdog_win_chk (
  input logic clk,
  input logic rst,
  input logic sleep_i,
  input logic sw_on,
  input logic cfg_hw_en,
  input logic cfg_rst_en,
  input logic cfg_win_dis,
  input logic rst_req,
  input logic trap_pulse,
  input logic win_open
);
  assert_rst_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> rst_req);

  assert_trap_no_rst_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_rst_en |=> !$rose(rst_req));

  assert_sleep_no_rst_R8: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> !$rose(rst_req));

  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!cfg_hw_en && !sw_on) |=> (!trap_pulse && !win_open));

  assert_nowin_open_R6: assert property (@(posedge clk) disable iff (rst)
    ((cfg_hw_en || sw_on) && cfg_win_dis) |=> win_open);

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (!rst_req && !trap_pulse && !win_open));

endmodule

bind watchdog_win watchdog_win_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sleep_i    (sleep_i),
  .sw_on      (sw_on),
  .cfg_hw_en  (cfg_hw_en),
  .cfg_rst_en (cfg_rst_en),
  .cfg_win_dis(cfg_win_dis),
  .rst_req    (rst_req),
  .trap_pulse (trap_pulse),
  .win_open   (win_open)
);

// File: tb/watchdog_win_test.sv
`timescale 1ns/1ps
module watchdog_win_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0, sleep_i = 1'b0, sw_clear = 1'b0, sw_on = 1'b0;
  logic       cfg_hw_en = 1'b1, cfg_rst_en = 1'b0, cfg_win_dis = 1'b1;
  logic [1:0] cfg_win_sel = 2'b00;
  logic [4:0] cfg_run_ps = 5'd3, cfg_sleep_ps = 5'd3;
  logic       rst_req, trap_pulse, win_open;

  int total = 0;
  int bad = 0;
  bit seen;

  always #2.5 clk = ~clk;

  watchdog_win uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .sleep_i(sleep_i),
    .sw_clear(sw_clear), .sw_on(sw_on), .cfg_hw_en(cfg_hw_en),
    .cfg_rst_en(cfg_rst_en), .cfg_win_dis(cfg_win_dis),
    .cfg_win_sel(cfg_win_sel), .cfg_run_ps(cfg_run_ps),
    .cfg_sleep_ps(cfg_sleep_ps), .rst_req(rst_req),
    .trap_pulse(trap_pulse), .win_open(win_open)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick_en = 1'b0; sw_clear = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic tick_n(input int k);
    seen = 1'b0;
    tick_en = 1'b1;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (trap_pulse || rst_req) seen = 1'b1;
    end
    tick_en = 1'b0;
  endtask

  task automatic edges_to_event(input int lim, output int n);
    n = 0;
    tick_en = 1'b1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (trap_pulse || rst_req) begin
        n = i;
        break;
      end
    end
    tick_en = 1'b0;
  endtask

  task automatic pulse_clear();
    sw_clear = 1'b1;
    @(negedge clk);
    sw_clear = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check(!rst_req && !trap_pulse, "R11", "outputs after reset", rst_req + trap_pulse, 0);
  endtask

  task automatic t_run_period();
    int n;
    cfg_hw_en = 1; cfg_rst_en = 0; cfg_win_dis = 1; sleep_i = 0;
    cfg_run_ps = 5'd3;
    do_reset();
    edges_to_event(40, n);
    check(n == 8, "R1", "run code 3 edges", n, 8);
    check(trap_pulse && !rst_req, "R7", "trap chosen when reset off", trap_pulse, 1);
    @(negedge clk);
    check(!trap_pulse, "R7", "trap is one cycle", trap_pulse, 0);
    cfg_run_ps = 5'd0;
    do_reset();
    edges_to_event(5, n);
    check(n == 1, "R1", "run code 0 edges", n, 1);
  endtask

  task automatic t_sleep_period();
    int n;
    sleep_i = 1; cfg_rst_en = 0; cfg_win_dis = 1;
    cfg_sleep_ps = 5'd0;
    do_reset();
    edges_to_event(10, n);
    check(n == 2, "R2", "sleep code 0 edges", n, 2);
    cfg_sleep_ps = 5'd1;
    do_reset();
    edges_to_event(10, n);
    check(n == 2, "R2", "sleep code 1 edges", n, 2);
    cfg_sleep_ps = 5'd4;
    do_reset();
    edges_to_event(40, n);
    check(n == 16, "R2", "sleep code 4 edges", n, 16);
    sleep_i = 0;
  endtask

  task automatic t_tick_gate();
    int n;
    cfg_run_ps = 5'd2; cfg_win_dis = 1; cfg_rst_en = 0;
    do_reset();
    n = 0;
    for (int i = 1; i <= 20; i++) begin
      tick_en = i[0];
      @(negedge clk);
      if (trap_pulse && n == 0) n = i;
    end
    tick_en = 0;
    check(n == 7, "R3", "edge of event with ticks on odd edges", n, 7);
  endtask

  task automatic t_window();
    int starts[4] = '{4, 8, 10, 12};
    int n;
    cfg_run_ps = 5'd4; cfg_win_dis = 0; cfg_rst_en = 0; sleep_i = 0;
    for (int s = 0; s < 4; s++) begin
      cfg_win_sel = 2'(s);
      do_reset();
      tick_n(starts[s] - 1);
      check(!win_open, "R4", "window shut before start", win_open, 0);
      tick_n(1);
      check(win_open, "R4", "window open at start", win_open, 1);
      pulse_clear();
      check(!trap_pulse, "R5", "clear in window no event", trap_pulse, 0);
      check(!win_open, "R5", "clear zeroes count", win_open, 0);
      edges_to_event(40, n);
      check(n == 16, "R5", "full period after good clear", n, 16);
      do_reset();
      tick_n(starts[s] - 1);
      pulse_clear();
      check(trap_pulse, "R5", "early clear raises event", trap_pulse, 1);
    end
  endtask

  task automatic t_window_off();
    int n;
    cfg_run_ps = 5'd3; cfg_win_dis = 1; cfg_rst_en = 0;
    do_reset();
    tick_n(1);
    check(win_open, "R6", "open while disabled", win_open, 1);
    pulse_clear();
    check(!trap_pulse, "R6", "clear at count 1 accepted", trap_pulse, 0);
    edges_to_event(40, n);
    check(n == 8, "R6", "count zeroed by clear", n, 8);
  endtask

  task automatic t_reset_outcome();
    int n;
    cfg_run_ps = 5'd2; cfg_win_dis = 1; cfg_rst_en = 1; sleep_i = 0;
    do_reset();
    edges_to_event(20, n);
    check(n == 4 && rst_req && !trap_pulse, "R7", "reset request on event", n, 4);
    tick_n(3);
    check(rst_req, "R7", "reset request held", rst_req, 1);
    sleep_i = 1; cfg_sleep_ps = 5'd2;
    do_reset();
    edges_to_event(20, n);
    check(n == 4 && trap_pulse && !rst_req, "R8", "sleep event is trap", rst_req, 0);
    sleep_i = 0; cfg_rst_en = 0;
  endtask

  task automatic t_enable();
    int n;
    cfg_hw_en = 0; sw_on = 0; cfg_run_ps = 5'd2; cfg_win_dis = 1;
    do_reset();
    tick_n(12);
    check(!seen && !win_open, "R9", "off means no event", seen, 0);
    sw_on = 1;
    edges_to_event(20, n);
    check(n == 4, "R9", "software on runs", n, 4);
    cfg_hw_en = 1; sw_on = 0;
  endtask

  task automatic t_sleep_change();
    int n;
    cfg_run_ps = 5'd3; cfg_sleep_ps = 5'd3; cfg_win_dis = 1; sleep_i = 0;
    do_reset();
    tick_n(5);
    sleep_i = 1;
    edges_to_event(30, n);
    check(n == 9, "R10", "mode change zeroes count", n, 9);
    sleep_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run hung, actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_run_period();
    t_sleep_period();
    t_tick_gate();
    t_window();
    t_window_off();
    t_reset_outcome();
    t_enable();
    t_sleep_change();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule